// File: doc/BRIEF.md
# Addressed Three-Wire Serial Control Port

This block is the slave side of a three-line serial control interface: an enable line, a serial clock and a data-in line, plus one open-drain data-out line. A host first clocks an 8-bit address into the port while the enable line is low. It then raises the enable line and clocks a frame.

The address picks one of three frame kinds:
- **Write A** and **Write B** each carry 24 data bits. The bits gather in a shift register and are copied into their own holding register only when the enable line falls.
- **Read** shifts a status snapshot out on data-out, one bit per clock. The snapshot holds the two I/O pin levels, the lock flag and a 20-bit count.

All three serial inputs are brought into the system clock domain through a two-stage synchroniser before edge detection. The host clock may idle high or idle low between transfers. The holding registers drive the rest of the chip directly.

Top module: `tri_wire_ctl_port`

## Requirements
- R1: Address bits are taken on rising serial clock edges while enable is low, and the last 8 taken form the address. They arrive in the order B0, B1, B2, B3, A0, A1, A2, A3, and the address value is {B3,B2,B1,B0,A3,A2,A1,A0}. 0x82 selects Write A, 0x92 selects Write B and 0xA2 selects Read. The address is decoded when enable rises.
- R2: In a Write A (Write B) frame, data bits are taken on rising serial clock edges while enable is high. The first bit taken lands in bit 0 of the 24-bit word. Only `ctl_word_a_o` (`ctl_word_b_o`) can be updated by that frame.
- R3: A holding register changes only when enable falls. It is written three system clocks after the enable pin falls, and it holds its value at all other times, including during the frame.
- R4: A write frame with fewer or more than 24 data bits leaves both holding registers unchanged.
- R5: A frame whose address is none of 0x82, 0x92 or 0xA2 updates no register and leaves data-out released throughout.
- R6: A Read frame sends, in order: `io_level_i[0]`, `io_level_i[1]`, `pll_locked_i` (1 = locked), then `if_count_i` MSB first. These 23 bits are a snapshot taken when enable rises; later input changes do not appear in that frame.
- R7: Data-out is open drain. `ser_dout_low_o` = 1 pulls the line low to send a 0, and 0 releases it to send a 1. The line is pulled low only during a Read frame; it is released during write frames, unknown frames and whenever enable is low.
- R8: One bit goes out per serial clock in a Read frame. Bits clocked after the 23rd read as 1 (released).
- R9: Both clock idle levels work. A Read bit advances on a falling serial clock edge, but only after the frame has seen its first rising edge, so a leading falling edge does not skip bit 0.
- R10: After reset both holding registers are zero and data-out is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_en_i | input | 1 | Serial enable line (asynchronous) |
| ser_clk_i | input | 1 | Serial clock line (asynchronous) |
| ser_din_i | input | 1 | Serial data-in line (asynchronous) |
| io_level_i | input | IO_W | Levels of the two shared I/O pins, reported in Read frames |
| pll_locked_i | input | 1 | Lock flag, 1 when locked |
| if_count_i | input | IFC_W | Frequency count value reported in Read frames |
| ctl_word_a_o | output | WORD_W | Holding register written by Write A frames |
| ctl_word_b_o | output | WORD_W | Holding register written by Write B frames |
| ser_dout_low_o | output | 1 | Open-drain data-out control, 1 pulls the line low |

## Verification
The bench keeps a behavioural model of the port and compares both holding registers and data-out on every quiet system clock. A wrong address register or mode shows within three clocks of the enable edge: either data-out pulls low in a frame that should leave it released, or a commit lands in the wrong word. A miscounted bit count or a misplaced shift appears as a wrong or missing update three clocks after enable falls. A wrong read pointer shows as a wrong line level on the very next bit the host samples.

// File: rtl/twc_pkg.sv
package twc_pkg;

    // Address codes, written as {B3,B2,B1,B0,A3,A2,A1,A0}
    localparam int          ADDR_W    = 8;
    localparam logic [7:0]  CODE_WR_A = 8'h82;
    localparam logic [7:0]  CODE_WR_B = 8'h92;
    localparam logic [7:0]  CODE_RD   = 8'hA2;
    localparam int          NUM_WR    = 2;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WR_A = 2'd1,
        MODE_WR_B = 2'd2,
        MODE_RD   = 2'd3
    } port_mode_e;

    // Synchronised view of the three serial lines
    typedef struct packed {
        logic en_lvl;
        logic en_rise;
        logic en_fall;
        logic clk_rise;
        logic clk_fall;
        logic din;
    } ser_evt_t;

    // Shift register holds the oldest bit (B0) in bit 7
    function automatic logic [7:0] arrival_to_code(input logic [7:0] sr);
        return {sr[4], sr[5], sr[6], sr[7], sr[0], sr[1], sr[2], sr[3]};
    endfunction

    function automatic port_mode_e decode_code(input logic [7:0] code);
        port_mode_e m;
        case (code)
            CODE_WR_A: m = MODE_WR_A;
            CODE_WR_B: m = MODE_WR_B;
            CODE_RD:   m = MODE_RD;
            default:   m = MODE_IDLE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/twc_sync.sv
module twc_sync
    import twc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en_pin,
    input  logic     clk_pin,
    input  logic     din_pin,
    output ser_evt_t evt
);
    localparam int LINES = 3;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev_q;

    assign pins = {din_pin, clk_pin, en_pin};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], pins[g]};
            end
            assign lvl[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    always_comb begin
        evt.en_lvl   = lvl[0];
        evt.en_rise  = lvl[0] & ~prev_q[0];
        evt.en_fall  = ~lvl[0] & prev_q[0];
        evt.clk_rise = lvl[1] & ~prev_q[1];
        evt.clk_fall = ~lvl[1] & prev_q[1];
        evt.din      = lvl[2];
    end

endmodule

// File: rtl/twc_frame_ctrl.sv
module twc_frame_ctrl
    import twc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  ser_evt_t          evt,
    output port_mode_e        mode_o,
    output logic              wr_shift_o,
    output logic [NUM_WR-1:0] commit_sel_o,
    output logic              rd_load_o,
    output logic              rd_shift_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] BITS_SAT  = CNT_W'(WORD_W + 1);

    logic [ADDR_W-1:0] addr_q;
    port_mode_e        mode_q;
    port_mode_e        next_mode;
    logic [CNT_W-1:0]  bits_q;
    logic              rose_q;
    logic              frame_full;
    logic              is_write;

    assign next_mode = decode_code(arrival_to_code(addr_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            mode_q <= MODE_IDLE;
            bits_q <= '0;
            rose_q <= 1'b0;
        end else begin
            if (evt.clk_rise && !evt.en_lvl)
                addr_q <= {addr_q[ADDR_W-2:0], evt.din};
            if (evt.en_rise) begin
                mode_q <= next_mode;
                bits_q <= '0;
                rose_q <= 1'b0;
            end else if (evt.en_fall) begin
                mode_q <= MODE_IDLE;
            end else if (evt.clk_rise && evt.en_lvl) begin
                rose_q <= 1'b1;
                if (bits_q != BITS_SAT)
                    bits_q <= bits_q + 1'b1;
            end
        end
    end

    assign frame_full = (bits_q == BITS_FULL);
    assign is_write   = (mode_q == MODE_WR_A) || (mode_q == MODE_WR_B);

    assign mode_o          = mode_q;
    assign wr_shift_o      = evt.clk_rise & evt.en_lvl & is_write;
    assign commit_sel_o[0] = evt.en_fall & frame_full & (mode_q == MODE_WR_A);
    assign commit_sel_o[1] = evt.en_fall & frame_full & (mode_q == MODE_WR_B);
    assign rd_load_o       = evt.en_rise & (next_mode == MODE_RD);
    assign rd_shift_o      = evt.clk_fall & evt.en_lvl & (mode_q == MODE_RD) & rose_q;

endmodule

// File: rtl/twc_write_bank.sv
module twc_write_bank
    import twc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_shift,
    input  logic                          din,
    input  logic [NUM_WR-1:0]             commit_sel,
    output logic [NUM_WR-1:0][WORD_W-1:0] words_o
);
    logic [WORD_W-1:0] shift_q;

    // First bit received ends in bit 0 after WORD_W shifts
    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (wr_shift) shift_q <= {din, shift_q[WORD_W-1:1]};
    end

    generate
        for (genvar g = 0; g < NUM_WR; g++) begin : g_hold
            always_ff @(posedge clk) begin
                if (rst)                words_o[g] <= '0;
                else if (commit_sel[g]) words_o[g] <= shift_q;
            end
        end
    endgenerate

endmodule

// File: rtl/twc_read_shift.sv
module twc_read_shift #(
    parameter int IO_W  = 2,
    parameter int IFC_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_load,
    input  logic             rd_shift,
    input  logic             mode_is_rd,
    input  logic [IO_W-1:0]  io_level,
    input  logic             locked,
    input  logic [IFC_W-1:0] count,
    output logic             dout_low_o
);
    localparam int FRAME_W = IO_W + 1 + IFC_W;

    logic [FRAME_W-1:0] shift_q;
    logic [IO_W-1:0]    io_rev;

    // io_level[0] must leave first, so it sits at the top
    always_comb begin
        for (int i = 0; i < IO_W; i++)
            io_rev[IO_W-1-i] = io_level[i];
    end

    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '1;
        else if (rd_load)  shift_q <= {io_rev, locked, count};
        else if (rd_shift) shift_q <= {shift_q[FRAME_W-2:0], 1'b1};
    end

    assign dout_low_o = mode_is_rd & ~shift_q[FRAME_W-1];

endmodule

// File: rtl/tri_wire_ctl_port.sv
module tri_wire_ctl_port
    import twc_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int IFC_W       = 20,
    parameter int IO_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_en_i,
    input  logic             ser_clk_i,
    input  logic             ser_din_i,
    input  logic [IO_W-1:0]  io_level_i,
    input  logic             pll_locked_i,
    input  logic [IFC_W-1:0] if_count_i,
    output logic [WORD_W-1:0] ctl_word_a_o,
    output logic [WORD_W-1:0] ctl_word_b_o,
    output logic             ser_dout_low_o
);
    ser_evt_t                     evt;
    port_mode_e                   mode;
    logic                         wr_shift;
    logic                         rd_load;
    logic                         rd_shift;
    logic [NUM_WR-1:0]            commit_sel;
    logic [NUM_WR-1:0][WORD_W-1:0] words;

    twc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .en_pin  (ser_en_i),
        .clk_pin (ser_clk_i),
        .din_pin (ser_din_i),
        .evt     (evt)
    );

    twc_frame_ctrl #(.WORD_W(WORD_W)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .mode_o       (mode),
        .wr_shift_o   (wr_shift),
        .commit_sel_o (commit_sel),
        .rd_load_o    (rd_load),
        .rd_shift_o   (rd_shift)
    );

    twc_write_bank #(.WORD_W(WORD_W)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .wr_shift   (wr_shift),
        .din        (evt.din),
        .commit_sel (commit_sel),
        .words_o    (words)
    );

    twc_read_shift #(.IO_W(IO_W), .IFC_W(IFC_W)) rd_i (
        .clk        (clk),
        .rst        (rst),
        .rd_load    (rd_load),
        .rd_shift   (rd_shift),
        .mode_is_rd (mode == MODE_RD),
        .io_level   (io_level_i),
        .locked     (pll_locked_i),
        .count      (if_count_i),
        .dout_low_o (ser_dout_low_o)
    );

    assign ctl_word_a_o = words[0];
    assign ctl_word_b_o = words[1];

endmodule

// File: rtl/twc_port_chk.sv
module twc_port_chk
    import twc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input ser_evt_t          evt,
    input port_mode_e        mode,
    input logic [NUM_WR-1:0] commit_sel,
    input logic              rd_load,
    input logic [WORD_W-1:0] word_a,
    input logic [WORD_W-1:0] word_b,
    input logic              dout_low
);
    AST_DOUT_ONLY_IN_READ: assert property (@(posedge clk) disable iff (rst)
        dout_low |-> (mode == MODE_RD)); // R7

    AST_COMMIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(commit_sel)); // R2

    AST_COMMIT_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        (|commit_sel) |-> evt.en_fall); // R3

    AST_WORD_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_sel[0] |=> $stable(word_a)); // R3

    AST_WORD_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_sel[1] |=> $stable(word_b)); // R3

    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        evt.en_fall |=> (mode == MODE_IDLE)); // R5

    AST_LOAD_ENTERS_READ: assert property (@(posedge clk) disable iff (rst)
        rd_load |=> (mode == MODE_RD)); // R6

endmodule

bind tri_wire_ctl_port twc_port_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .mode       (mode),
    .commit_sel (commit_sel),
    .rd_load    (rd_load),
    .word_a     (ctl_word_a_o),
    .word_b     (ctl_word_b_o),
    .dout_low   (ser_dout_low_o)
);

// File: tb/tri_wire_ctl_port_tb.sv
module tri_wire_ctl_port_tb_top;
    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic [1:0]  io_lvl = 2'b10;
    logic        locked = 1'b1;
    logic [19:0] cnt = 20'h53980;
    logic [23:0] word_a, word_b;
    logic        dout_low;

    always #10 clk = ~clk;

    tri_wire_ctl_port dut_i (
        .clk(clk), .rst(rst), .ser_en_i(ser_en), .ser_clk_i(ser_clk),
        .ser_din_i(ser_din), .io_level_i(io_lvl), .pll_locked_i(locked),
        .if_count_i(cnt), .ctl_word_a_o(word_a), .ctl_word_b_o(word_b),
        .ser_dout_low_o(dout_low)
    );

    int checks = 0, fails = 0;
    int cyc = 0, last_chg = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Behavioural model
    logic [23:0] exp_a = '0, exp_b = '0;
    bit addr_hist[$];
    bit wr_q[$];
    bit rd_q[$];
    int m_mode = 0;   // 0 none, 1 write A, 2 write B, 3 read
    bit m_rose = 0, m_ce = 0, m_clk = 0;

    function automatic bit exp_dlow();
        if (m_mode == 3 && rd_q.size() > 0) return !rd_q[0];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Per-clock comparison once the pins have been quiet long enough
    always @(negedge clk) begin
        if (!rst && (cyc - last_chg) >= 4) begin
            check("R2 R3 word A per-clock", 64'(word_a), 64'(exp_a));
            check("R2 R3 word B per-clock", 64'(word_b), 64'(exp_b));
            check("R7 dout per-clock", 64'(dout_low), 64'(exp_dlow()));
        end
    end

    task automatic set_din(input bit v);
        ser_din = v; last_chg = cyc; wait_clks(H);
    endtask

    task automatic set_clk(input bit v);
        if (v != m_clk) begin
            if (v) begin
                if (!m_ce) begin
                    addr_hist.push_back(ser_din);
                    if (addr_hist.size() > 8) void'(addr_hist.pop_front());
                end else begin
                    m_rose = 1;
                    if (m_mode == 1 || m_mode == 2) wr_q.push_back(ser_din);
                end
            end else if (m_ce && m_mode == 3 && m_rose && rd_q.size() > 0) begin
                void'(rd_q.pop_front());
            end
        end
        m_clk = v; ser_clk = v; last_chg = cyc; wait_clks(H);
    endtask

    task automatic set_ce(input bit v);
        logic [7:0] code;
        logic [23:0] w;
        if (v && !m_ce) begin
            code = 8'h00;
            if (addr_hist.size() == 8)
                code = {addr_hist[3], addr_hist[2], addr_hist[1], addr_hist[0],
                        addr_hist[7], addr_hist[6], addr_hist[5], addr_hist[4]};
            case (code)
                8'h82:   m_mode = 1;
                8'h92:   m_mode = 2;
                8'hA2:   m_mode = 3;
                default: m_mode = 0;
            endcase
            m_rose = 0;
            wr_q.delete();
            rd_q.delete();
            if (m_mode == 3) begin
                rd_q.push_back(io_lvl[0]);
                rd_q.push_back(io_lvl[1]);
                rd_q.push_back(locked);
                for (int j = 19; j >= 0; j--) rd_q.push_back(cnt[j]);
            end
        end else if (!v && m_ce) begin
            if (wr_q.size() == 24) begin
                for (int i = 0; i < 24; i++) w[i] = wr_q[i];
                if (m_mode == 1) exp_a = w;
                if (m_mode == 2) exp_b = w;
            end
            m_mode = 0;
        end
        m_ce = v; ser_en = v; last_chg = cyc; wait_clks(H);
    endtask

    task automatic pulse(input bit idle_hi, input bit v, output bit line);
        set_din(v);
        if (idle_hi) begin
            set_clk(0); set_clk(1); line = !dout_low;
        end else begin
            set_clk(1); line = !dout_low; set_clk(0);
        end
    endtask

    task automatic send_addr(input bit idle_hi, input logic [7:0] code);
        bit b;
        for (int i = 0; i < 8; i++)
            pulse(idle_hi, (i < 4) ? code[4+i] : code[i-4], b);
    endtask

    task automatic send_bits(input bit idle_hi, input int n, input logic [63:0] data,
                             output logic [63:0] got);
        bit b;
        got = '1;
        for (int i = 0; i < n; i++) begin
            pulse(idle_hi, data[i], b);
            got[i] = b;
        end
    endtask

    task automatic frame(input bit idle_hi, input logic [7:0] code, input int n,
                         input logic [63:0] data, output logic [63:0] got);
        if (idle_hi) set_clk(1); else set_clk(0);
        send_addr(idle_hi, code);
        set_ce(1);
        send_bits(idle_hi, n, data, got);
        set_ce(0);
    endtask

    function automatic logic [63:0] rd_expect(input logic [1:0] io, input logic lk,
                                              input logic [19:0] c);
        logic [63:0] e;
        e = '1;
        e[0] = io[0];
        e[1] = io[1];
        e[2] = lk;
        for (int j = 0; j < 20; j++) e[3+j] = c[19-j];
        return e;
    endfunction

    logic [63:0] got, e;

    initial begin
        repeat (5) @(posedge clk);
        rst = 1'b0;
        last_chg = cyc;
        wait_clks(4);
        check("R10 reset word A", 64'(word_a), 64'h0);
        check("R10 reset word B", 64'(word_b), 64'h0);
        check("R10 reset dout released", 64'(dout_low), 64'h0);

        // Write A, idle-low clock
        frame(0, 8'h82, 24, 64'hA5C3F1, got);
        check("R2 write A", 64'(word_a), 64'hA5C3F1);
        check("R2 word B untouched", 64'(word_b), 64'h0);

        // Write B, idle-high clock
        frame(1, 8'h92, 24, 64'h3C0FF0, got);
        check("R9 write B idle-high", 64'(word_b), 64'h3C0FF0);
        check("R2 word A kept", 64'(word_a), 64'hA5C3F1);
        set_clk(0);

        // Commit happens only at the enable fall
        send_addr(0, 8'h82);
        set_ce(1);
        send_bits(0, 24, 64'h123456, got);
        check("R3 word A held before enable falls", 64'(word_a), 64'hA5C3F1);
        check("R7 dout released in write frame", 64'(dout_low), 64'h0);
        set_ce(0);
        check("R3 word A after enable falls", 64'(word_a), 64'h123456);

        // Short and long frames
        frame(0, 8'h82, 10, 64'h3FF, got);
        check("R4 short frame ignored", 64'(word_a), 64'h123456);
        frame(1, 8'h92, 30, 64'h2AAAAAAA, got);
        check("R4 long frame ignored", 64'(word_b), 64'h3C0FF0);
        set_clk(0);

        // Unknown addresses
        send_addr(0, 8'h83);
        set_ce(1);
        send_bits(0, 24, 64'h000000, got);
        check("R5 dout released in unknown frame", 64'(dout_low), 64'h0);
        check("R5 unknown frame line level", got, 64'hFFFFFFFFFFFFFFFF);
        set_ce(0);
        check("R5 word A untouched", 64'(word_a), 64'h123456);
        frame(0, 8'h22, 24, 64'hFFFFFF, got);
        check("R5 word B untouched", 64'(word_b), 64'h3C0FF0);

        // Extra leading address bits: only the last 8 count
        begin
            bit b;
            pulse(0, 1, b); pulse(0, 1, b); pulse(0, 0, b); pulse(0, 1, b);
        end
        send_addr(0, 8'h92);
        set_ce(1);
        send_bits(0, 24, 64'h00C0DE, got);
        set_ce(0);
        check("R1 last eight address bits decide", 64'(word_b), 64'h00C0DE);

        // Read frames
        frame(0, 8'hA2, 23, 64'h0, got);
        check("R6 read idle-low", got & 64'h7FFFFF, rd_expect(io_lvl, locked, cnt) & 64'h7FFFFF);
        io_lvl = 2'b01; locked = 1'b0; cnt = 20'h00E10;
        frame(0, 8'hA2, 27, 64'h0, got);
        e = rd_expect(io_lvl, locked, cnt);
        check("R8 read with extra clocks", got & 64'h7FFFFFF, e & 64'h7FFFFFF);
        check("R8 bits after 23 are released", (got >> 23) & 64'hF, 64'hF);
        io_lvl = 2'b11; cnt = 20'hF0F0F;
        frame(1, 8'hA2, 23, 64'h0, got);
        check("R9 read idle-high", got & 64'h7FFFFF,
              rd_expect(io_lvl, locked, cnt) & 64'h7FFFFF);
        set_clk(0);

        // Snapshot taken at enable rise
        io_lvl = 2'b10; locked = 1'b1; cnt = 20'h12345;
        e = rd_expect(io_lvl, locked, cnt);
        send_addr(0, 8'hA2);
        set_ce(1);
        io_lvl = 2'b01; locked = 1'b0; cnt = 20'hEDCBA;
        send_bits(0, 23, 64'h0, got);
        set_ce(0);
        check("R6 snapshot at enable rise", got & 64'h7FFFFF, e & 64'h7FFFFF);
        check("R7 dout released after read", 64'(dout_low), 64'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 act=timeout exp=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule